// File: doc/BRIEF.md
# Dual-Channel Interrupt Cause Unit

This block collects interrupt causes for two engine channels into one shared cause register and one shared enable (mask) register. Each channel owns a 16-bit half of each register: channel n sits in bits [16n+15:16n]. A channel raises single-cycle event pulses, one bit per cause. The pulses set sticky bits in its half of the cause register. Software reads the register and clears causes by writing zeros. Because a written one leaves a bit alone, the service routine for one channel can clear its own causes without disturbing the other channel.

The bit layout inside a half is a convention shared with the engines, not something the logic decodes:
- The completion group sits in the low bits: descriptor done at bit 0, chain done at bit 1 and channel stopped at bit 2. Software normally clears these three together.
- The error causes sit higher in the half, with the address-decode error at bit 9.

Each channel has its own interrupt line. The line is a registered OR of that channel's cause bits that are enabled in the mask.

Top module: `icu_dual_cause`

## Requirements
- R1: After reset, the cause register and the mask register both read zero and every interrupt line is low.
- R2: An event pulse on bit 16n+k of `chan_evt` sets cause bit 16n+k at the next clock edge. Bit 0 of a half is descriptor done, bit 1 is chain done, bit 2 is stopped and bit 9 is address-decode error.
- R3: A set cause bit stays set, with or without further events, until software clears it.
- R4: A write with `reg_sel`=0 clears every cause bit written as 0 and leaves every bit written as 1 unchanged. A write of all ones changes nothing, and a write that zeros only one half leaves the other half intact.
- R5: If a clearing write and an event for the same bit come in the same cycle, the bit is set after that edge.
- R6: A write with `reg_sel`=1 replaces the whole mask register. Without such a write the mask keeps its value. A mask bit of 1 enables the cause bit in the same position.
- R7: `chan_irq[n]` is high in the cycle after a cycle in which channel n has a cause bit and the matching mask bit both set. Otherwise it is low, so causes that are masked off never raise the line.
- R8: `reg_rdata` shows the full cause register when `reg_sel`=0 and the mask register when `reg_sel`=1. Reading changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all state |
| reg_wr | input | 1 | Write strobe for the register selected by reg_sel |
| reg_sel | input | 1 | 0 selects the cause register, 1 selects the mask register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| chan_evt | input | 32 | Event pulses, channel n in bits [16n+15:16n] |
| chan_irq | output | 2 | Interrupt line per channel |

## Verification
The bench aims first at a clear and an event landing on the same bit in the same edge. A design that let the write win would lose that event. It then writes all ones, and writes that zero only one channel's half. A write-one-to-clear or whole-register-clear design would wipe the neighbouring channel's causes there. It also checks that the line stays low when pending causes are masked off, and that it rises exactly one cycle after a cause and its enable meet. A wrong mask AND or a missing output register would shift or leak the interrupt. Random write data, sparse random events and random mask values run against a bench model of the sticky clear rule.

// File: rtl/icu_pkg.sv
package icu_pkg;
   typedef enum logic {
      SEL_CAUSE = 1'b0,
      SEL_MASK  = 1'b1
   } icu_sel_e;

   localparam int unsigned CAUSE_DESC_DONE  = 0;
   localparam int unsigned CAUSE_CHAIN_DONE = 1;
   localparam int unsigned CAUSE_STOPPED    = 2;
   localparam int unsigned CAUSE_ADDR_ERR   = 9;
endpackage

// File: rtl/icu_chan_slice.sv
module icu_chan_slice #(
   parameter int unsigned CH_W    = 16,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cause_wr,
   input  logic            mask_wr,
   input  logic [CH_W-1:0] wdata,
   input  logic [CH_W-1:0] evt,
   output logic [CH_W-1:0] cause_q,
   output logic [CH_W-1:0] mask_q,
   output logic            irq
);
   logic [CH_W-1:0] cause_d;
   logic [CH_W-1:0] mask_d;
   logic            pend;

   // zero clears, one keeps; the event is ORed in after the clear so it wins
   always_comb begin
      cause_d = cause_wr ? (cause_q & wdata) : cause_q;
      cause_d = cause_d | evt;
      mask_d  = mask_wr ? wdata : mask_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= '0;
         mask_q  <= '0;
      end else begin
         cause_q <= cause_d;
         mask_q  <= mask_d;
      end
   end

   assign pend = |(cause_q & mask_q);

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= pend;
         end
         assign irq = irq_q;

         a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_q == '0) |=> !irq);
      end else begin : g_irq_comb
         assign irq = pend;
      end
   endgenerate

   a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !cause_wr |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

   a_r4_ones_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_wr && (wdata == '1)) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

   a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((cause_q & $past(evt)) == $past(evt)));

   a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr |=> $stable(mask_q));
endmodule

// File: rtl/icu_read_mux.sv
module icu_read_mux #(
   parameter int unsigned REG_W = 32
) (
   input  icu_pkg::icu_sel_e sel,
   input  logic [REG_W-1:0]  cause,
   input  logic [REG_W-1:0]  mask,
   output logic [REG_W-1:0]  rdata
);
   always_comb begin
      unique case (sel)
         icu_pkg::SEL_CAUSE: rdata = cause;
         default:            rdata = mask;
      endcase
   end
endmodule

// File: rtl/icu_dual_cause.sv
module icu_dual_cause #(
   parameter int unsigned NUM_CH  = 2,
   parameter int unsigned CH_W    = 16,
   parameter bit          IRQ_REG = 1'b1,
   localparam int unsigned REG_W  = NUM_CH * CH_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [REG_W-1:0]  chan_evt,
   output logic [NUM_CH-1:0] chan_irq
);
   import icu_pkg::*;

   if (NUM_CH < 1) begin : g_chk_ch
      $error("icu_dual_cause: NUM_CH must be at least 1");
   end
   if (CH_W <= CAUSE_ADDR_ERR) begin : g_chk_w
      $error("icu_dual_cause: CH_W too narrow for the cause layout");
   end

   icu_sel_e         sel;
   logic             cause_wr;
   logic             mask_wr;
   logic [REG_W-1:0] cause_all;
   logic [REG_W-1:0] mask_all;

   assign sel      = icu_sel_e'(reg_sel);
   assign cause_wr = reg_wr && (sel == SEL_CAUSE);
   assign mask_wr  = reg_wr && (sel == SEL_MASK);

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      icu_chan_slice #(
         .CH_W    (CH_W),
         .IRQ_REG (IRQ_REG)
      ) i_slice (
         .clk      (clk),
         .rst_n    (rst_n),
         .cause_wr (cause_wr),
         .mask_wr  (mask_wr),
         .wdata    (reg_wdata[n*CH_W +: CH_W]),
         .evt      (chan_evt[n*CH_W +: CH_W]),
         .cause_q  (cause_all[n*CH_W +: CH_W]),
         .mask_q   (mask_all[n*CH_W +: CH_W]),
         .irq      (chan_irq[n])
      );
   end

   icu_read_mux #(.REG_W(REG_W)) i_rmux (
      .sel   (sel),
      .cause (cause_all),
      .mask  (mask_all),
      .rdata (reg_rdata)
   );

   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (cause_all == '0 || !rst_n));

   a_r8_read_no_side: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && chan_evt == '0) |=> ($stable(cause_all) && $stable(mask_all)));
endmodule

// File: tb/test_icu_dual_cause.sv
module test_icu_dual_cause;
   localparam int NUM_CH = 2;
   localparam int CH_W   = 16;
   localparam int REG_W  = NUM_CH * CH_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic              reg_sel = 1'b0;
   logic [REG_W-1:0]  reg_wdata = '0;
   logic [REG_W-1:0]  reg_rdata;
   logic [REG_W-1:0]  chan_evt = '0;
   logic [NUM_CH-1:0] chan_irq;

   int total = 0;
   int bad   = 0;

   logic [REG_W-1:0]  m_cause = '0;
   logic [REG_W-1:0]  m_mask  = '0;
   logic [NUM_CH-1:0] m_irq   = '0;

   always #4 clk = ~clk;

   icu_dual_cause i_icu_dual_cause (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .chan_evt  (chan_evt),
      .chan_irq  (chan_irq)
   );

   function automatic logic [REG_W-1:0] f_cause(logic [REG_W-1:0] c, logic wr, logic sel,
                                                logic [REG_W-1:0] wd, logic [REG_W-1:0] ev);
      logic [REG_W-1:0] r;
      r = (wr && !sel) ? (c & wd) : c;
      return r | ev;
   endfunction

   function automatic logic [NUM_CH-1:0] f_irq(logic [REG_W-1:0] c, logic [REG_W-1:0] m);
      logic [NUM_CH-1:0] r;
      for (int n = 0; n < NUM_CH; n++) r[n] = |(c[n*CH_W +: CH_W] & m[n*CH_W +: CH_W]);
      return r;
   endfunction

   task automatic check(string tag, logic [REG_W-1:0] act, logic [REG_W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic observe(string tag);
      reg_wr = 1'b0; chan_evt = '0;
      reg_sel = 1'b0; #1;
      check({tag, " cause R8"}, reg_rdata, m_cause);
      reg_sel = 1'b1; #1;
      check({tag, " mask R6"}, reg_rdata, m_mask);
      check({tag, " irq R7"}, {{(REG_W-NUM_CH){1'b0}}, chan_irq}, {{(REG_W-NUM_CH){1'b0}}, m_irq});
   endtask

   task automatic step(string tag, logic wr, logic sel, logic [REG_W-1:0] wd, logic [REG_W-1:0] ev);
      @(negedge clk);
      reg_wr = wr; reg_sel = sel; reg_wdata = wd; chan_evt = ev;
      @(posedge clk);
      #1;
      m_irq   = f_irq(m_cause, m_mask);
      m_cause = f_cause(m_cause, wr, sel, wd, ev);
      if (wr && sel) m_mask = wd;
      observe(tag);
   endtask

   initial begin
      #(8 * 200000);
      bad++; total++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1;
      observe("R1 reset");
      @(negedge clk); rst_n = 1'b1;

      // R2: descriptor done on ch0, address error on ch1
      step("R2 set", 1'b0, 1'b0, '0, 32'h0200_0001);
      // R3: stays with no activity
      step("R3 hold", 1'b0, 1'b0, '0, '0);
      step("R3 hold2", 1'b0, 1'b0, '0, 32'h0000_0004);
      // R7: masked off -> line stays low, then enable ch1 only
      step("R7 enable", 1'b1, 1'b1, 32'h0200_0000, '0);
      step("R7 rise", 1'b0, 1'b0, '0, '0);
      // R4: all ones keeps everything
      step("R4 ones", 1'b1, 1'b0, 32'hFFFF_FFFF, '0);
      // R4: clear ch0 completion group only, ch1 untouched
      step("R4 half", 1'b1, 1'b0, 32'hFFFF_FFF8, '0);
      // R5: clear and event on same bit
      step("R5 race", 1'b1, 1'b0, 32'h0000_FFFF, 32'h0200_0000);
      step("R7 after", 1'b1, 1'b0, 32'h0000_0000, '0);
      step("R7 fall", 1'b0, 1'b0, '0, '0);

      for (int i = 0; i < 400; i++) begin
         logic wr, sel;
         logic [REG_W-1:0] wd, ev;
         wr  = ($urandom % 4) == 0;
         sel = $urandom % 2;
         wd  = $urandom | $urandom;
         ev  = $urandom & $urandom & $urandom;
         step("R2/R3/R4/R5 rand", wr, sel, wd, ev);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule